// File: doc/BRIEF.md
# Top-Level Channel Fork-Join Adapter

This block sits between the decoupled boundary of a simulated system and the per-module token queues inside it. Tokens come in on one external input channel and leave on one external output channel. Each input token is split over several destination queues, and each destination queue gets only the signals its module reads. Several source queues are joined so that one output token is offered, with each output signal taken from the queue that carries it from the module that produces it.

The routing is fixed when the block is built. For each input signal, a bit mask names the destination queues that receive it. For each output signal, an index names the source queue it comes from. A second mask marks the signals that are clocks. Clock slots carry zero in every payload. The block is purely combinational. The clock and the active-low reset are used only by the built-in property checks.

Payloads are packed slot by slot, with each slot `SW` bits wide. Input signal `i` is at bits `[i*SW +: SW]` of `ext_in_data`. Destination queue `d` has a full copy of the input slot layout, starting at bit `d*N_IN*SW` of `enq_data`. Source queue `s` has a full copy of the output slot layout, starting at bit `s*N_OUT*SW` of `deq_data`.

Top module: `topio_fork_join`

## Requirements
- R1: `ext_in_ready` is high exactly when every bit of `enq_ready` is high.
- R2: All bits of `enq_valid` are high together, in exactly the cycles where `ext_in_valid` and `ext_in_ready` are both high, and are low otherwise. A token therefore enters every destination queue in the same cycle, or enters none of them.
- R3: Slot `i` of destination `d` equals input slot `i` when bit `i*N_DST+d` of `IN_ROUTE` is set and the signal is not a clock. Otherwise that slot is zero.
- R4: A signal flagged in `IN_CLK` or `OUT_CLK` appears as zero in every enqueue payload and in the external output payload, whatever the source drives.
- R5: `ext_out_valid` is high exactly when every bit of `deq_valid` is high.
- R6: All bits of `deq_ready` are high together, in exactly the cycles where `ext_out_valid` and `ext_out_ready` are both high, and are low otherwise.
- R7: Output slot `k` equals slot `k` of source queue `OUT_SRC[k*SRCW +: SRCW]`.
- R8: Over a long stream with irregular ready and valid patterns on all sides, every destination queue receives every input token exactly once and in order. Every output token takes exactly one entry from each source queue, and no output token is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the property checks only |
| rst_n | input | 1 | Active-low reset for the property checks |
| ext_in_valid | input | 1 | External input token offered |
| ext_in_ready | output | 1 | External input token accepted |
| ext_in_data | input | N_IN*SW | External input payload, one slot per signal |
| enq_valid | output | N_DST | Enqueue valid, one bit per destination queue |
| enq_ready | input | N_DST | Enqueue ready, one bit per destination queue |
| enq_data | output | N_DST*N_IN*SW | Enqueue payloads of all destination queues |
| deq_valid | input | N_SRC | Dequeue valid, one bit per source queue |
| deq_ready | output | N_SRC | Dequeue ready, one bit per source queue |
| deq_data | input | N_SRC*N_OUT*SW | Dequeue payloads of all source queues |
| ext_out_valid | output | 1 | External output token offered |
| ext_out_ready | input | 1 | External output token taken |
| ext_out_data | output | N_OUT*SW | External output payload |

## Verification
The bench builds the block with its default parameters:
- Three 4-bit input signals over two destination queues. One signal goes to one queue only, one goes to both, and the third is flagged as a clock.
- Two output signals taken from two source queues in crossed order, so that output slot 0 comes from queue 1.

These settings bring partial routing, clock scrubbing and the slot-to-queue index mapping within reach. A ready/valid table exercises partial readiness on both sides. A long run with random ready and valid patterns on all sides then checks that no token is lost or repeated.

// File: rtl/topio_fork_join.sv
module topio_fork_join #(
  parameter int SW    = 4,
  parameter int N_IN  = 3,
  parameter int N_DST = 2,
  parameter int N_OUT = 2,
  parameter int N_SRC = 2,
  localparam int SRCW = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  parameter logic [N_IN*N_DST-1:0] IN_ROUTE = 6'b111101,
  parameter logic [N_IN-1:0]       IN_CLK   = 3'b100,
  parameter logic [N_OUT*SRCW-1:0] OUT_SRC  = 2'b01,
  parameter logic [N_OUT-1:0]      OUT_CLK  = 2'b00
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ext_in_valid,
  output logic                      ext_in_ready,
  input  logic [N_IN*SW-1:0]        ext_in_data,
  output logic [N_DST-1:0]          enq_valid,
  input  logic [N_DST-1:0]          enq_ready,
  output logic [N_DST*N_IN*SW-1:0]  enq_data,
  input  logic [N_SRC-1:0]          deq_valid,
  output logic [N_SRC-1:0]          deq_ready,
  input  logic [N_SRC*N_OUT*SW-1:0] deq_data,
  output logic                      ext_out_valid,
  input  logic                      ext_out_ready,
  output logic [N_OUT*SW-1:0]       ext_out_data
);
  logic fire_in, fire_out, unused_bits;

  assign ext_in_ready = &enq_ready;
  assign fire_in      = ext_in_valid & ext_in_ready;
  assign enq_valid    = {N_DST{fire_in}};

  for (genvar d = 0; d < N_DST; d++) begin : g_dst
    for (genvar i = 0; i < N_IN; i++) begin : g_sig
      if (IN_ROUTE[i*N_DST+d] && !IN_CLK[i]) begin : g_on
        assign enq_data[(d*N_IN+i)*SW +: SW] = ext_in_data[i*SW +: SW];
      end else begin : g_off
        assign enq_data[(d*N_IN+i)*SW +: SW] = '0;
      end
    end
  end

  assign ext_out_valid = &deq_valid;
  assign fire_out      = ext_out_valid & ext_out_ready;
  assign deq_ready     = {N_SRC{fire_out}};

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int S = int'(OUT_SRC[k*SRCW +: SRCW]);
    if (OUT_CLK[k]) begin : g_clk
      assign ext_out_data[k*SW +: SW] = '0;
    end else begin : g_pass
      assign ext_out_data[k*SW +: SW] = deq_data[(S*N_OUT+k)*SW +: SW];
    end
  end

  assign unused_bits = ^{ext_in_data, deq_data};

  AST_IN_READY_ALL: assert property (@(posedge clk) disable iff (!rst_n) ext_in_ready |-> (&enq_ready)); // R1
  AST_ENQ_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n) (|enq_valid) |-> (&enq_valid)); // R2
  AST_ENQ_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n) (|enq_valid) |-> (ext_in_valid && (&enq_ready))); // R2
  AST_OUT_VALID_ALL: assert property (@(posedge clk) disable iff (!rst_n) ext_out_valid |-> (&deq_valid)); // R5
  AST_DEQ_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n) (|deq_ready) |-> (&deq_ready)); // R6
  AST_DEQ_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n) (|deq_ready) |-> (ext_out_ready && (&deq_valid))); // R6
endmodule

// File: tb/topio_fork_join_tb_top.sv
module topio_fork_join_tb_top;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic        ext_in_valid, ext_in_ready, ext_out_valid, ext_out_ready;
  logic [11:0] ext_in_data;
  logic [1:0]  enq_valid, enq_ready, deq_valid, deq_ready;
  logic [23:0] enq_data;
  logic [15:0] deq_data;
  logic [7:0]  ext_out_data;
  int n_chk = 0, n_fail = 0;

  topio_fork_join dut_i (.clk, .rst_n, .ext_in_valid, .ext_in_ready, .ext_in_data,
    .enq_valid, .enq_ready, .enq_data, .deq_valid, .deq_ready, .deq_data,
    .ext_out_valid, .ext_out_ready, .ext_out_data);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {in_valid, enq_ready[1:0], deq_valid[1:0], out_ready | in_ready, enq_valid[1:0], out_valid, deq_ready[1:0]}
  localparam logic [11:0] VEC [8] = '{
    12'b1_11_11_1_1_11_1_11,
    12'b1_01_11_1_0_00_1_11,
    12'b0_11_10_1_1_00_0_00,
    12'b1_10_01_0_0_00_0_00,
    12'b1_11_11_0_1_11_1_00,
    12'b0_00_00_0_0_00_0_00,
    12'b1_00_11_1_0_00_1_11,
    12'b1_11_01_1_1_11_0_00
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [3:0] s0, s1, q1s1, q1s0, q0s1, q0s0;
    int p, c0, c1, r0, r1, oc, err;
    ext_in_valid = 0; enq_ready = 0; ext_in_data = 0;
    deq_valid = 0; deq_data = 0; ext_out_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    check({ext_in_ready, enq_valid, ext_out_valid, deq_ready} == 0, "R1 R5 reset state",
          {ext_in_ready, enq_valid, ext_out_valid, deq_ready}, 0);
    rst_n = 1;

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      s0 = 4'(i*5+1); s1 = 4'(i+3);
      q1s1 = 4'(i); q1s0 = 4'(i+9); q0s1 = 4'(i+2); q0s0 = ~4'(i);
      {ext_in_valid, enq_ready, deq_valid, ext_out_ready} = VEC[i][11:6];
      ext_in_data = {4'hF, s1, s0};
      deq_data = {q1s1, q1s0, q0s1, q0s0};
      #1;
      check({ext_in_ready, enq_valid, ext_out_valid, deq_ready} == VEC[i][5:0], "R1 R2 R5 R6 handshake",
            {ext_in_ready, enq_valid, ext_out_valid, deq_ready}, VEC[i][5:0]);
      check(enq_data == {4'h0, s1, 4'h0, 4'h0, s1, s0}, "R3 R4 fork payload",
            enq_data, {4'h0, s1, 4'h0, 4'h0, s1, s0});
      check(ext_out_data == {q0s1, q1s0}, "R7 join payload", ext_out_data, {q0s1, q1s0});
    end

    // R4: clock slot alone changes, every enqueue payload stays zero
    @(negedge clk);
    ext_in_data = 12'hA00; #1;
    check(enq_data == 0, "R4 clock slot scrubbed", enq_data, 0);

    // R8: random streaming through fork and join
    p = 0; c0 = 0; c1 = 0; r0 = 0; r1 = 0; oc = 0; err = 0;
    ext_in_valid = 0;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (!ext_in_valid) ext_in_valid = ($urandom % 3) != 0;
      ext_in_data = {4'h5, 4'(p >> 4) ^ 4'hA, 4'(p)};
      enq_ready = 2'($urandom);
      deq_valid = 2'($urandom) | 2'($urandom);
      ext_out_ready = ($urandom % 4) != 0;
      deq_data = {4'h0, 4'(c1), 4'(c0), 4'h0};
      #1;
      if (enq_valid[0] && enq_ready[0]) begin
        if (enq_data[7:0] != {4'(r0 >> 4) ^ 4'hA, 4'(r0)}) err++;
        r0++;
      end
      if (enq_valid[1] && enq_ready[1]) begin
        if (enq_data[23:12] != {4'h0, 4'(r1 >> 4) ^ 4'hA, 4'h0}) err++;
        r1++;
      end
      if (ext_in_valid && ext_in_ready) begin p++; ext_in_valid = 0; end
      if (deq_valid[0] && deq_ready[0]) c0++;
      if (deq_valid[1] && deq_ready[1]) c1++;
      if (ext_out_valid && ext_out_ready) begin
        if (ext_out_data != {4'(oc), 4'(oc)}) err++;
        oc++;
      end
      if (c0 != c1 || r0 != r1) err++;
    end
    check(err == 0, "R8 stream order and alignment", err, 0);
    check(r0 == p && r1 == p && p > 100, "R8 fork token count", r1, p);
    check(c0 == oc && c1 == oc && oc > 100, "R8 join token count", c0, oc);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule